// File: doc/BRIEF.md
# HARQ Subpacket Deselection Address Generator

This block prepares a turbo decoder input buffer for one received subpacket. A start pulse captures four values: the number of allocated slots, a modulation code, the subpacket identifier (0 to 3) and the frame size N counted in symbol pairs. From these values the block works out two numbers. The first is how many soft values the subpacket carries. The second is the circular position in the 6N-entry buffer at which writing of those values begins.

Neither number needs a multiplier. The length comes from one shift-add whose shift amounts depend on the modulation. The offset comes from a fixed-length remainder step followed by a short modulo-6N accumulation, repeated once per unit of subpacket identifier.

While this arithmetic runs, the block also drives a zero-fill pass over all 6N buffer entries. Any position the subpacket does not supply therefore reads as zero. The block raises a single-cycle done strobe only after both the arithmetic and the zero-fill have finished. The results stay on the outputs until the next completed request.

Top module: `spd_desel_addr_gen`

## Requirements
- R1: The length output equals 48 · m · slots. The modulation code selects m as follows: code 0 gives m = 2, code 1 gives m = 4, and codes 2 and 3 both give m = 6.
- R2: When the subpacket identifier is 0, the offset output is 0.
- R3: When the subpacket identifier s is 1, 2 or 3, the offset output equals (s · length) mod 6N and lies in the range 0 to 6N-1.
- R4: After an accepted start, the zero-fill pass writes every address from 0 to 6N-1 exactly once. It writes one address per cycle in ascending order, with write data equal to zero.
- R5: After reset, the done strobe, the write enable, the length output and the offset output are all zero. The write enable is never high while no request is in progress.
- R6: The done strobe is high for exactly one cycle per request. It rises only after the last zero-fill write. The length and offset outputs change only in the cycle in which done is high, and they hold their values afterwards.
- R7: A start pulse that arrives while a request is in progress is ignored. The results and the zero-fill range of the running request stay those of the first request.
- R8: All four inputs are captured when the start pulse is accepted. Changing them afterwards has no effect on the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| start | input | 1 | Request pulse; accepted only while idle |
| nsch | input | NSCH_W | Number of allocated slots (1 to 480) |
| mod_code | input | 2 | Modulation code (0: m=2, 1: m=4, 2 or 3: m=6) |
| spid | input | 2 | Subpacket identifier, 0 to 3 |
| n_pairs | input | N_W | Frame size N in symbol pairs, at least 1 |
| len_out | output | NSCH_W+9 | Number of soft values in the subpacket |
| off_out | output | N_W+3 | Circular start offset in the buffer |
| done | output | 1 | One-cycle strobe when results are valid and the zero-fill is complete |
| clr_we | output | 1 | Write enable for the zero-fill pass |
| clr_addr | output | N_W+3 | Address for the zero-fill pass |
| clr_data | output | SW | Write data for the zero-fill pass (always zero) |

## Verification
The properties assume that the frame size is at least one symbol pair. With that assumption the buffer size 6N is non-zero, and the last address 6N-1 does not wrap. They also assume the slot count is within the range the length width can hold. The sweep respects both limits: frame sizes run from 1 to 31 pairs, and slot counts include 1 and 480. A second start and scrambled input values are applied during some requests. This shows that the captured values, and therefore the address range the properties compare against, stay fixed until done.

// File: rtl/spd_pkg.sv
package spd_pkg;

   // modulation selector; the two upper codes share the m = 6 path
   typedef enum logic [1:0] {
      MODC_M2  = 2'd0,
      MODC_M4  = 2'd1,
      MODC_M6  = 2'd2,
      MODC_M6B = 2'd3
   } modc_e;

   // offset engine phases
   typedef enum logic [1:0] {
      OFS_IDLE = 2'd0,
      OFS_DIV  = 2'd1,
      OFS_ACC  = 2'd2
   } ofs_state_e;

endpackage

// File: rtl/spd_len_calc.sv
module spd_len_calc #(
   parameter int NSCH_W = 9,
   parameter int LW     = NSCH_W + 9
) (
   input  logic [NSCH_W-1:0] nsch,
   input  logic [1:0]        mod_code,
   output logic [LW-1:0]     len
);
   import spd_pkg::*;

   localparam int BW = NSCH_W + 4;

   logic [BW-1:0] n_ext;
   logic [BW-1:0] base;
   logic [LW-1:0] base_ext;
   logic          wide_sel;
   logic          quad_sel;

   assign wide_sel = mod_code[1];
   assign quad_sel = (modc_e'(mod_code) == MODC_M4);
   assign n_ext    = {4'b0000, nsch};

   // 3n for m = 2 or 4, 9n for m = 6
   assign base = n_ext + (wide_sel ? (n_ext << 3) : (n_ext << 1));

   generate
      if (LW > BW) begin : g_ext
         assign base_ext = {{(LW-BW){1'b0}}, base};
      end else begin : g_trunc
         assign base_ext = base[LW-1:0];
      end
   endgenerate

   // times 64 for m = 4, times 32 otherwise
   assign len = quad_sel ? (base_ext << 6) : (base_ext << 5);

endmodule

// File: rtl/spd_offset_unit.sv
module spd_offset_unit #(
   parameter int LW = 18,
   parameter int AW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [LW-1:0] len_in,
   input  logic [AW-1:0] m6n,
   input  logic [1:0]    spid,
   output logic [AW-1:0] off,
   output logic          valid
);
   import spd_pkg::*;

   localparam int CW = LW + AW;
   localparam int KW = (LW > 1) ? $clog2(LW) : 1;
   localparam logic [KW-1:0] K_TOP = KW'(LW - 1);

   ofs_state_e    st;
   logic [LW-1:0] rem;
   logic [KW-1:0] k;
   logic [AW-1:0] acc;
   logic [1:0]    cnt;

   logic [CW-1:0] rem_w;
   logic [CW-1:0] div_w;
   logic [CW-1:0] rem_sub;
   logic          take;
   logic [AW:0]   sum;
   logic [AW:0]   fold;

   // restoring remainder step: subtract 6N << k when it fits
   assign rem_w   = {{AW{1'b0}}, rem};
   assign div_w   = {{LW{1'b0}}, m6n} << k;
   assign take    = (rem_w >= div_w);
   assign rem_sub = rem_w - div_w;

   // modular accumulation of the reduced length
   assign sum  = {1'b0, acc} + {1'b0, rem_w[AW-1:0]};
   assign fold = (sum >= {1'b0, m6n}) ? (sum - {1'b0, m6n}) : sum;

   assign off = acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= OFS_IDLE;
         rem   <= '0;
         k     <= '0;
         acc   <= '0;
         cnt   <= '0;
         valid <= 1'b0;
      end else if (go) begin
         st    <= OFS_DIV;
         rem   <= len_in;
         k     <= K_TOP;
         acc   <= '0;
         cnt   <= spid;
         valid <= 1'b0;
      end else begin
         case (st)
            OFS_DIV: begin
               if (take) rem <= rem_sub[LW-1:0];
               if (k == '0) st <= OFS_ACC;
               else         k  <= k - 1'b1;
            end
            OFS_ACC: begin
               if (cnt == 2'd0) begin
                  valid <= 1'b1;
                  st    <= OFS_IDLE;
               end else begin
                  acc <= fold[AW-1:0];
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= OFS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spd_clear_seq.sv
module spd_clear_seq #(
   parameter int AW = 15,
   parameter int SW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] m6n,
   output logic          we,
   output logic [AW-1:0] addr,
   output logic [SW-1:0] data,
   output logic          fin
);
   logic          active;
   logic [AW-1:0] last_addr;

   assign last_addr = m6n - AW'(1);
   assign we        = active;
   assign data      = '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         addr   <= '0;
         fin    <= 1'b0;
      end else if (go) begin
         active <= 1'b1;
         addr   <= '0;
         fin    <= 1'b0;
      end else if (active) begin
         if (addr == last_addr) begin
            active <= 1'b0;
            fin    <= 1'b1;
         end else begin
            addr <= addr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/spd_desel_addr_gen.sv
module spd_desel_addr_gen #(
   parameter int NSCH_W = 9,
   parameter int N_W    = 12,
   parameter int SW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NSCH_W-1:0] nsch,
   input  logic [1:0]        mod_code,
   input  logic [1:0]        spid,
   input  logic [N_W-1:0]    n_pairs,
   output logic [NSCH_W+8:0] len_out,
   output logic [N_W+2:0]    off_out,
   output logic              done,
   output logic              clr_we,
   output logic [N_W+2:0]    clr_addr,
   output logic [SW-1:0]     clr_data
);
   localparam int LW = NSCH_W + 9;
   localparam int AW = N_W + 3;

   generate
      if (NSCH_W < 9) begin : g_bad_nsch
         $error("NSCH_W must hold a slot count of 480");
      end
      if (N_W < 1) begin : g_bad_nw
         $error("N_W must be at least 1");
      end
      if (SW < 1) begin : g_bad_sw
         $error("SW must be at least 1");
      end
   endgenerate

   logic              busy_q;
   logic              go_q;
   logic              done_q;
   logic [NSCH_W-1:0] lat_nsch;
   logic [1:0]        lat_mod;
   logic [1:0]        lat_spid;
   logic [AW-1:0]     m6n_q;
   logic [AW-1:0]     m6n_w;
   logic [LW-1:0]     len_w;
   logic [LW-1:0]     len_q;
   logic [AW-1:0]     off_q;
   logic [AW-1:0]     ofs_off;
   logic              ofs_valid;
   logic              clr_fin;

   // 6N as 4N + 2N
   assign m6n_w = ({3'b000, n_pairs} << 2) + ({3'b000, n_pairs} << 1);

   spd_len_calc #(.NSCH_W(NSCH_W), .LW(LW)) u_len (
      .nsch     (lat_nsch),
      .mod_code (lat_mod),
      .len      (len_w)
   );

   spd_offset_unit #(.LW(LW), .AW(AW)) u_ofs (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go_q),
      .len_in (len_w),
      .m6n    (m6n_q),
      .spid   (lat_spid),
      .off    (ofs_off),
      .valid  (ofs_valid)
   );

   spd_clear_seq #(.AW(AW), .SW(SW)) u_clr (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go_q),
      .m6n   (m6n_q),
      .we    (clr_we),
      .addr  (clr_addr),
      .data  (clr_data),
      .fin   (clr_fin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         go_q     <= 1'b0;
         done_q   <= 1'b0;
         lat_nsch <= '0;
         lat_mod  <= '0;
         lat_spid <= '0;
         m6n_q    <= '0;
         len_q    <= '0;
         off_q    <= '0;
      end else begin
         done_q <= 1'b0;
         go_q   <= 1'b0;
         if (!busy_q && start) begin
            busy_q   <= 1'b1;
            go_q     <= 1'b1;
            lat_nsch <= nsch;
            lat_mod  <= mod_code;
            lat_spid <= spid;
            m6n_q    <= m6n_w;
         end else if (busy_q && !go_q && clr_fin && ofs_valid) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            len_q  <= len_w;
            off_q  <= ofs_off;
         end
      end
   end

   assign done    = done_q;
   assign len_out = len_q;
   assign off_out = off_q;

endmodule

// File: rtl/spd_desel_chk.sv
module spd_desel_chk #(
   parameter int LW = 18,
   parameter int AW = 15,
   parameter int SW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          done,
   input logic          clr_we,
   input logic [AW-1:0] clr_addr,
   input logic [SW-1:0] clr_data,
   input logic [LW-1:0] len_out,
   input logic [AW-1:0] off_out,
   input logic [AW-1:0] m6n,
   input logic          busy
);
   // R4
   clr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && (clr_addr != m6n - AW'(1))) |=> (clr_we && (clr_addr == AW'($past(clr_addr) + 1'b1))));

   // R4
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |-> (clr_data == '0));

   // R4
   clr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |-> (clr_addr < m6n));

   // R3
   off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (off_out < m6n));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !clr_we);

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(len_out) || !$stable(off_out)) |-> done);

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !clr_we);

   // R7
   frame_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(m6n));

endmodule

bind spd_desel_addr_gen spd_desel_chk #(.LW(LW), .AW(AW), .SW(SW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .clr_we   (clr_we),
   .clr_addr (clr_addr),
   .clr_data (clr_data),
   .len_out  (len_out),
   .off_out  (off_out),
   .m6n      (m6n_q),
   .busy     (busy_q)
);

// File: tb/spd_desel_addr_gen_tb.sv
`timescale 1ns/1ps
module spd_desel_addr_gen_tb;
   localparam int NSCH_W = 9;
   localparam int N_W    = 5;
   localparam int SW     = 6;
   localparam int LW     = NSCH_W + 9;
   localparam int AW     = N_W + 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [NSCH_W-1:0] nsch = '0;
   logic [1:0]        mod_code = '0;
   logic [1:0]        spid = '0;
   logic [N_W-1:0]    n_pairs = '0;
   logic [LW-1:0]     len_out;
   logic [AW-1:0]     off_out;
   logic              done;
   logic              clr_we;
   logic [AW-1:0]     clr_addr;
   logic [SW-1:0]     clr_data;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   spd_desel_addr_gen #(.NSCH_W(NSCH_W), .N_W(N_W), .SW(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .nsch(nsch),
      .mod_code(mod_code), .spid(spid), .n_pairs(n_pairs),
      .len_out(len_out), .off_out(off_out), .done(done),
      .clr_we(clr_we), .clr_addr(clr_addr), .clr_data(clr_data)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_case(input int ns, input int mc, input int sp, input int np, input bit second_start);
      longint m, exp_len, exp_off, size;
      int wcnt, bad, cyc;
      bit seen;
      m       = (mc == 0) ? 2 : ((mc == 1) ? 4 : 6);
      exp_len = 48 * m * ns;
      size    = 6 * np;
      exp_off = (sp * exp_len) % size;
      wcnt = 0; bad = 0; cyc = 0; seen = 1'b0;
      @(negedge clk);
      nsch = NSCH_W'(ns); mod_code = 2'(mc); spid = 2'(sp); n_pairs = N_W'(np);
      start = 1'b1;
      while (!seen && cyc < 400) begin
         @(negedge clk);
         if (clr_we) begin
            if (clr_addr != AW'(wcnt) || clr_data != '0) bad++;
            wcnt++;
         end
         if (done) seen = 1'b1;
         if (cyc == 0) begin
            start = 1'b0;
            // R8: scramble inputs after capture
            nsch = NSCH_W'(100); mod_code = ~mod_code; spid = ~spid; n_pairs = N_W'(2);
         end
         if (cyc == 2 && second_start) start = 1'b1;
         if (cyc == 3) start = 1'b0;
         cyc++;
      end
      check(seen, "R6 done seen", seen, 1);
      check(len_out == LW'(exp_len), "R1 R8 length", len_out, exp_len);
      if (sp == 0) check(off_out == '0, "R2 offset zero", off_out, 0);
      else         check(off_out == AW'(exp_off), "R3 offset", off_out, exp_off);
      if (second_start) check(wcnt == size, "R7 clear count after ignored start", wcnt, size);
      else              check(wcnt == size, "R4 clear count", wcnt, size);
      check(bad == 0, "R4 clear order and data", bad, 0);
      @(negedge clk);
      check(!done, "R6 done single pulse", done, 0);
      check(len_out == LW'(exp_len) && off_out == AW'(exp_off), "R6 results held", off_out, exp_off);
      check(!clr_we, "R5 write idle", clr_we, 0);
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int nlist [4] = '{1, 3, 7, 31};
      int slist [4] = '{1, 5, 333, 480};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state
      check(!done && !clr_we, "R5 reset strobes", {done, clr_we}, 0);
      check(len_out == '0 && off_out == '0, "R5 reset results", len_out, 0);
      foreach (nlist[i]) begin
         foreach (slist[j]) begin
            for (int mc = 0; mc < 4; mc++) begin
               for (int sp = 0; sp < 4; sp++) begin
                  run_case(slist[j], mc, sp, nlist[i], (mc == sp));
               end
            end
         end
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule